// File: doc/BRIEF.md
# Touch Panel Driver Switch Controller

This block sits beside a successive-approximation converter that digitises a four-corner resistive touch panel. Each clock it looks at the decoded channel code, the reference-mode bit, the power-down code, the converter's current phase and chip select. From these it works out which corner switches must be closed, which way the panel is biased, whether the pen-detect path is connected, and which source feeds the converter input.

For a position measurement all four corners are used. The upper-right and lower-left corners take opposite supply polarities, and that polarity picks the axis. In single-ended reference mode the panel is powered only while the sample is acquired. In ratiometric mode it stays powered through the conversion as well. In the always-powered mode the drives can stay closed between conversions, as long as nothing in the configuration changes. In one power-down mode only the lower-right corner is grounded and the pen-detect path is connected, so that a touch pulls the detect line low. All outputs are registered and change one clock after their inputs.

Top module: `touch_sw_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is 0 at the next clock edge.
- R2: If `cs_n` is high at a clock edge, every output is 0 after that edge, and any held drive is dropped.
- R3: Channel code 3'b001 selects the Y axis. When phase code 1 (acquire) is active, the edge closes all four corner switches, sets `ur_hi`=1, sets `pen_gnd`=1 and sets `mux_sel`=2'b01 (panel sense).
- R4: Channel code 3'b101 selects the X axis. It behaves as R3 except that `ur_hi`=0.
- R5: With `ratio`=0 and a power-down code other than 2'b11, phase code 2 (convert) opens all corner switches.
- R6: With `ratio`=1, an X or Y channel in phase code 2 keeps the drives of R3/R4 closed.
- R7: In phase code 3 (power-down) with power-down code 2'b00, only `lr_en` is closed, `pen_en`=1 and `mux_sel`=0.
- R8: In phase code 3 with power-down code 2'b01 or 2'b10, every output is 0.
- R9: With power-down code 2'b11, closed X/Y drives stay closed in phases 0 and 2 for as long as the channel, `ratio` and power-down code are unchanged from the previous cycle. A change in any of them, `cs_n` high or phase code 3 opens them.
- R10: `pen_gnd` is 1 exactly when the corner drives of an X/Y measurement are closed. `pen_en` is never 1 at the same time as `ul_en`, `ur_en` or `ll_en`.
- R11: Channel code 3'b010 (auxiliary) closes no corner switch and sets `mux_sel`=2'b10 in phases 1 and 2. Every other channel apart from 3'b001 and 3'b101 closes no corner switch and sets `mux_sel`=0.
- R12: Every output reflects the inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, high deselects |
| chan | input | 3 | Decoded channel code |
| ratio | input | 1 | 1 = ratiometric reference, 0 = single-ended |
| pd | input | 2 | Power-down code |
| phase | input | 2 | 0 idle, 1 acquire, 2 convert, 3 power-down |
| ul_en | output | 1 | Upper-left switch closed (to supply) |
| ur_en | output | 1 | Upper-right switch closed |
| ll_en | output | 1 | Lower-left switch closed |
| lr_en | output | 1 | Lower-right switch closed (to ground) |
| ur_hi | output | 1 | 1: upper-right to supply, lower-left to ground; 0: reversed |
| pen_en | output | 1 | Pen-detect path connected to the panel sense node |
| pen_gnd | output | 1 | Pen-detect node forced to ground, isolated from sense |
| mux_sel | output | 2 | Converter input: 0 none, 1 panel sense, 2 auxiliary |

## Verification
The block has no parameters, so the bench builds it as written. It walks every combination of channel, reference mode, power-down code and phase, always after an acquire cycle with the same settings. This covers the hold path of R9 and the power-down grounding of R7 from a powered panel. Directed sequences then change one configuration field at a time during a hold, deselect in the middle of a conversion, and apply reset during active drive.

// File: rtl/touch_sw_ctrl.sv
module touch_sw_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic [2:0] chan,
  input  logic       ratio,
  input  logic [1:0] pd,
  input  logic [1:0] phase,
  output logic       ul_en,
  output logic       ur_en,
  output logic       ll_en,
  output logic       lr_en,
  output logic       ur_hi,
  output logic       pen_en,
  output logic       pen_gnd,
  output logic [1:0] mux_sel
);
  localparam logic [2:0] CH_Y   = 3'b001;
  localparam logic [2:0] CH_X   = 3'b101;
  localparam logic [2:0] CH_AUX = 3'b010;
  localparam logic [1:0] PH_ACQ  = 2'd1;
  localparam logic [1:0] PH_CONV = 2'd2;
  localparam logic [1:0] PH_PD   = 2'd3;
  localparam logic [1:0] PD_GND  = 2'b00;
  localparam logic [1:0] PD_ON   = 2'b11;
  localparam int CFG_W = 6;

  logic [CFG_W-1:0] cfg, cfg_q;
  logic on_q;

  assign cfg = {chan, ratio, pd};

  wire is_xy   = (chan == CH_Y) || (chan == CH_X);
  wire sampling = (phase == PH_ACQ) || (phase == PH_CONV);
  wire keep    = (pd == PD_ON) && on_q && (cfg == cfg_q) && (phase != PH_PD);
  wire drive   = is_xy && ((phase == PH_ACQ) || ((phase == PH_CONV) && ratio) || keep);
  wire sleep_gnd = (phase == PH_PD) && (pd == PD_GND);

  always_ff @(posedge clk) begin
    cfg_q <= rst_n ? cfg : '0;
    if (!rst_n || cs_n) begin
      on_q    <= 1'b0;
      ul_en   <= 1'b0;
      ur_en   <= 1'b0;
      ll_en   <= 1'b0;
      lr_en   <= 1'b0;
      ur_hi   <= 1'b0;
      pen_en  <= 1'b0;
      pen_gnd <= 1'b0;
      mux_sel <= 2'd0;
    end else begin
      on_q    <= drive;
      ul_en   <= drive;
      ur_en   <= drive;
      ll_en   <= drive;
      lr_en   <= drive || sleep_gnd;
      ur_hi   <= drive && (chan == CH_Y);
      pen_en  <= sleep_gnd;
      pen_gnd <= drive;
      mux_sel <= drive ? 2'd1 : ((chan == CH_AUX && sampling) ? 2'd2 : 2'd0);
    end
  end
endmodule

// File: rtl/touch_sw_ctrl_chk.sv
module touch_sw_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [2:0] chan,
  input logic       ratio,
  input logic [1:0] pd,
  input logic [1:0] phase,
  input logic       ul_en,
  input logic       ur_en,
  input logic       ll_en,
  input logic       lr_en,
  input logic       pen_en,
  input logic       pen_gnd,
  input logic [1:0] mux_sel
);
  p_cs_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !(ul_en || ur_en || ll_en || lr_en || pen_en || pen_gnd));
  p_se_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && phase == 2'd2 && !ratio && pd != 2'b11) |=> !(ul_en || ur_en || ll_en));
  p_ratio_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && phase == 2'd2 && ratio && (chan == 3'b001 || chan == 3'b101)) |=> (ul_en && ll_en && mux_sel == 2'd1));
  p_pd_gnd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && phase == 2'd3 && pd == 2'b00) |=> (lr_en && pen_en && !ul_en && !ur_en && !ll_en));
  p_pen_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pen_en |-> !(ul_en || ur_en || ll_en || pen_gnd));
  p_aux_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && chan == 3'b010) |=> !(ul_en || ur_en || ll_en || pen_gnd));
endmodule

bind touch_sw_ctrl touch_sw_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .chan(chan), .ratio(ratio), .pd(pd),
  .phase(phase), .ul_en(ul_en), .ur_en(ur_en), .ll_en(ll_en), .lr_en(lr_en),
  .pen_en(pen_en), .pen_gnd(pen_gnd), .mux_sel(mux_sel)
);

// File: tb/touch_sw_ctrl_bench.sv
module touch_sw_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic [2:0] chan = '0;
  logic ratio = 1'b0;
  logic [1:0] pd = '0;
  logic [1:0] phase = '0;
  logic ul_en, ur_en, ll_en, lr_en, ur_hi, pen_en, pen_gnd;
  logic [1:0] mux_sel;

  int n_chk = 0, n_bad = 0;
  int m_on = 0, m_chan = 0, m_ratio = 0, m_pd = 0;
  int e_ul, e_ur, e_ll, e_lr, e_hi, e_pen, e_gnd, e_mux;

  always #5 clk = ~clk;

  touch_sw_ctrl u_touch_sw_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .chan(chan), .ratio(ratio), .pd(pd),
    .phase(phase), .ul_en(ul_en), .ur_en(ur_en), .ll_en(ll_en), .lr_en(lr_en),
    .ur_hi(ur_hi), .pen_en(pen_en), .pen_gnd(pen_gnd), .mux_sel(mux_sel)
  );

  task automatic model();
    int c = int'(chan), r = int'(ratio), p = int'(pd), ph = int'(phase);
    bit xy = (c == 1) || (c == 5);
    bit on;
    e_ul = 0; e_ur = 0; e_ll = 0; e_lr = 0; e_hi = 0; e_pen = 0; e_gnd = 0; e_mux = 0;
    if (!rst_n || cs_n) begin
      m_on = 0;
    end else begin
      on = xy && (ph == 1 || (ph == 2 && r == 1) ||
                  (p == 3 && m_on == 1 && c == m_chan && r == m_ratio && p == m_pd && ph != 3));
      m_on = on;
      if (on) begin
        e_ul = 1; e_ur = 1; e_ll = 1; e_lr = 1; e_gnd = 1; e_mux = 1;
        e_hi = (c == 1) ? 1 : 0;
      end else if (c == 2 && (ph == 1 || ph == 2)) begin
        e_mux = 2;
      end
      if (ph == 3 && p == 0) begin
        e_lr = 1; e_pen = 1;
      end
    end
    if (rst_n) begin
      m_chan = c; m_ratio = r; m_pd = p;
    end else begin
      m_chan = 0; m_ratio = 0; m_pd = 0;
    end
  endtask

  task automatic step(input bit s_cs, input int s_ch, input bit s_r, input int s_pd,
                      input int s_ph, input string tag);
    cs_n = s_cs; chan = 3'(s_ch); ratio = s_r; pd = 2'(s_pd); phase = 2'(s_ph);
    @(posedge clk);
    model();
    @(negedge clk);
    n_chk++;
    if ({ul_en, ur_en, ll_en, lr_en, ur_hi, pen_en, pen_gnd, mux_sel} !==
        {1'(e_ul), 1'(e_ur), 1'(e_ll), 1'(e_lr), 1'(e_hi), 1'(e_pen), 1'(e_gnd), 2'(e_mux)}) begin
      n_bad++;
      $display("FAIL %s: got ul%0b ur%0b ll%0b lr%0b hi%0b pen%0b gnd%0b mux%0d exp ul%0d ur%0d ll%0d lr%0d hi%0d pen%0d gnd%0d mux%0d",
               tag, ul_en, ur_en, ll_en, lr_en, ur_hi, pen_en, pen_gnd, mux_sel,
               e_ul, e_ur, e_ll, e_lr, e_hi, e_pen, e_gnd, e_mux);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(1'b0, 1, 1'b1, 3, 1, "R1 reset");
    step(1'b0, 5, 1'b0, 0, 3, "R1 reset");
    rst_n = 1'b1;
    step(1'b1, 1, 1'b0, 0, 1, "R2 deselected");
    step(1'b0, 1, 1'b0, 0, 1, "R3 Y acquire");
    step(1'b0, 1, 1'b0, 0, 2, "R5 Y convert single-ended");
    step(1'b0, 1, 1'b0, 0, 3, "R7 pd00 ground");
    step(1'b0, 5, 1'b0, 1, 1, "R4 X acquire");
    step(1'b0, 5, 1'b0, 1, 2, "R5 X convert single-ended");
    step(1'b0, 5, 1'b0, 1, 3, "R8 pd01 off");
    step(1'b0, 5, 1'b1, 2, 1, "R4 X acquire ratio");
    step(1'b0, 5, 1'b1, 2, 2, "R6 ratio convert");
    step(1'b0, 5, 1'b1, 2, 2, "R6 ratio convert");
    step(1'b1, 5, 1'b1, 2, 2, "R2 deselect mid convert");
    step(1'b0, 5, 1'b1, 2, 3, "R8 pd10 off");
    step(1'b0, 1, 1'b0, 3, 1, "R9 acquire pd11");
    step(1'b0, 1, 1'b0, 3, 2, "R9 hold convert");
    step(1'b0, 1, 1'b0, 3, 0, "R9 hold idle");
    step(1'b0, 1, 1'b1, 3, 0, "R9 ratio change drops");
    step(1'b0, 1, 1'b1, 3, 0, "R9 stays dropped");
    step(1'b0, 5, 1'b0, 3, 1, "R9 acquire pd11");
    step(1'b0, 1, 1'b0, 3, 0, "R9 channel change drops");
    step(1'b0, 5, 1'b0, 3, 1, "R9 acquire pd11");
    step(1'b0, 5, 1'b0, 0, 2, "R9 pd change drops");
    step(1'b0, 5, 1'b0, 3, 1, "R9 acquire pd11");
    step(1'b1, 5, 1'b0, 3, 0, "R9 cs drops hold");
    step(1'b0, 5, 1'b0, 3, 0, "R9 no hold after cs");
    step(1'b0, 2, 1'b0, 3, 1, "R11 aux acquire");
    step(1'b0, 2, 1'b0, 3, 2, "R11 aux convert");
    step(1'b0, 6, 1'b0, 0, 1, "R11 pen-test channel");
    step(1'b0, 6, 1'b0, 0, 3, "R10 pen path");
    step(1'b0, 1, 1'b1, 3, 1, "R10 drive grounds pen");
    rst_n = 1'b0;
    step(1'b0, 1, 1'b1, 3, 2, "R1 reset during drive");
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 2; r++)
        for (int p = 0; p < 4; p++)
          for (int ph = 0; ph < 4; ph++) begin
            step(1'b0, c, 1'(r), p, 1, "R12 sweep prior acquire");
            step(1'b0, c, 1'(r), p, ph, "R12 sweep");
          end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule